// File: doc/BRIEF.md
# Bitplane Fetch Address Generator

This block holds the display fetch addresses for up to six bitplanes, numbered 1 to 6. Each plane owns an 18-bit word pointer. The host loads it through two write-only halves: a 3-bit upper part and a 15-bit lower part. A fetch scheduler outside the block names one plane per request. The block answers one cycle later with that plane's current word address, and it advances the pointer by one word.

At the end of every displayed line, a signed modulo is added to every pointer so that each points at the first word of its next line. Planes 1, 3 and 5 use the odd-plane modulo. Planes 2, 4 and 6 use the even-plane modulo. The two groups can therefore walk bitmaps of different widths. The block never rewinds a pointer by itself. The host must reload all pointers during each vertical blank.

Two kinds of state machine sit inside the block. Each pointer slot decodes one operation per cycle: `OP_HOLD`, `OP_STEP`, `OP_LINE` or `OP_STEP_LINE`, and a host write overrides that operation. The issue stage has two states. It moves from `ISS_IDLE` to `ISS_VALID` when it accepts a request for a legal plane. It returns to `ISS_IDLE` on any cycle without such a request. It stays in `ISS_VALID` while back-to-back legal requests arrive.

Top module: `bpl_ptr_gen`

## Requirements
- R1: After reset, all six pointers and both modulos are zero, and `fetch_valid` is low.
- R2: A request with `fetch_req` high and `fetch_plane` from 1 to 6 makes `fetch_valid` high in the next cycle. In that cycle `fetch_addr` holds the pointer value from before the request and `fetch_plane_o` echoes the plane number. With no legal request, `fetch_valid` is low in the next cycle.
- R3: Each accepted request adds one to that plane's pointer. The addition wraps from 18'h3FFFF to 0.
- R4: `host_kind` 2'b00 writes `host_data[14:0]` into pointer bits 14:0 and keeps bits 17:15. `host_kind` 2'b01 writes `host_data[2:0]` into bits 17:15 and keeps bits 14:0. All other data bits are ignored. The target plane is given by `host_plane`.
- R5: A plane code of 0 or 7 has no effect. As a fetch it yields no `fetch_valid` and changes no pointer. As a pointer write it changes no pointer.
- R6: A `line_end` pulse adds the odd modulo, sign-extended from 16 to 18 bits, to pointers 1, 3 and 5. It adds the even modulo, extended the same way, to pointers 2, 4 and 6. The sums wrap modulo 2^18.
- R7: `host_kind` 2'b10 loads the odd modulo and 2'b11 loads the even modulo, both from `host_data[15:0]`. A modulo write in the same cycle as `line_end` does not affect that line end; the old value is used.
- R8: When a pointer write hits a plane in the same cycle as a fetch or line end for that plane, the write wins. The written half takes the new data and the other half keeps its old value, with no step and no modulo applied. The fetch still returns the old pointer.
- R9: A fetch and a `line_end` hitting the same plane in one cycle add both one and the plane's modulo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_kind | input | 2 | Write target: 00 pointer low, 01 pointer high, 10 odd modulo, 11 even modulo |
| host_plane | input | 3 | Plane number for pointer writes (1 to 6) |
| host_data | input | 16 | Write data |
| fetch_req | input | 1 | Fetch request for one plane |
| fetch_plane | input | 3 | Plane number of the request (1 to 6) |
| line_end | input | 1 | End-of-line pulse that applies the modulos |
| fetch_valid | output | 1 | Issued address is valid this cycle |
| fetch_addr | output | 18 | Issued word address |
| fetch_plane_o | output | 3 | Plane the issued address belongs to |

## Verification
Directed sequences first establish the pieces one at a time:
- Single fetches expose the reset value and the one-word step.
- Writes to one half at a time show that the other half is kept and that stray data bits are dropped.
- A pointer parked at the top of the address range separates a wrapping step from a carry into a missing bit.
- Opposite-signed odd and even modulos, followed by a fetch of every plane, show that parity routing is right and that sign extension is right.

Deliberate collisions then pin down the priority rules. These are a write against a fetch, a write against a line end, a modulo write against a line end, and a fetch against a line end. Finally a long run of mixed random traffic is checked against a behavioural model of all six pointers on every clock.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

    // Host write target encoding
    typedef enum logic [1:0] {
        HK_PTR_LO   = 2'b00,
        HK_PTR_HI   = 2'b01,
        HK_MOD_ODD  = 2'b10,
        HK_MOD_EVEN = 2'b11
    } host_kind_e;

    // Per-slot pointer operation for one cycle
    typedef enum logic [1:0] {
        OP_HOLD      = 2'b00,
        OP_STEP      = 2'b01,
        OP_LINE      = 2'b10,
        OP_STEP_LINE = 2'b11
    } slot_op_e;

    // Issue stage states
    typedef enum logic {
        ISS_IDLE  = 1'b0,
        ISS_VALID = 1'b1
    } iss_state_e;

endpackage

// File: rtl/bpl_mod_regs.sv
module bpl_mod_regs #(
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       kind,
    input  logic [MOD_W-1:0] data,
    output logic [MOD_W-1:0] mod_odd,
    output logic [MOD_W-1:0] mod_even
);
    import bpl_pkg::*;

    logic [MOD_W-1:0] odd_q, even_q;
    logic             ld_odd, ld_even;

    always_comb begin
        ld_odd  = 1'b0;
        ld_even = 1'b0;
        if (we) begin
            unique case (host_kind_e'(kind))
                HK_MOD_ODD:  ld_odd  = 1'b1;
                HK_MOD_EVEN: ld_even = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q  <= '0;
            even_q <= '0;
        end else begin
            if (ld_odd)  odd_q  <= data;
            if (ld_even) even_q <= data;
        end
    end

    assign mod_odd  = odd_q;
    assign mod_even = even_q;

    // R7: a modulo write lands in the selected register only
    a_r7_odd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == 2'b10) |=> (mod_odd == $past(data) && $stable(mod_even)));
    a_r7_even_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == 2'b11) |=> (mod_even == $past(data) && $stable(mod_odd)));

endmodule

// File: rtl/bpl_ptr_slot.sv
module bpl_ptr_slot #(
    parameter int HI_W   = 3,
    parameter int LO_W   = 15,
    parameter int MOD_W  = 16,
    parameter int DATA_W = 16,
    localparam int PTR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    input  logic              line_end,
    input  logic [MOD_W-1:0]  modulo,
    output logic [PTR_W-1:0]  ptr
);
    import bpl_pkg::*;

    localparam int EXT_W = PTR_W - MOD_W;

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [PTR_W-1:0] mod_ext;
    slot_op_e         op;

    assign mod_ext = {{EXT_W{modulo[MOD_W-1]}}, modulo};

    // Operation decode
    always_comb begin
        unique case ({line_end, step})
            2'b01:   op = OP_STEP;
            2'b10:   op = OP_LINE;
            2'b11:   op = OP_STEP_LINE;
            default: op = OP_HOLD;
        endcase
    end

    // Next pointer; host write overrides any arithmetic
    always_comb begin
        unique case (op)
            OP_STEP:      ptr_d = ptr_q + PTR_W'(1);
            OP_LINE:      ptr_d = ptr_q + mod_ext;
            OP_STEP_LINE: ptr_d = ptr_q + mod_ext + PTR_W'(1);
            default:      ptr_d = ptr_q;
        endcase
        if (wr_hi) ptr_d = {wr_data[HI_W-1:0], ptr_q[LO_W-1:0]};
        if (wr_lo) ptr_d = {ptr_q[PTR_W-1:LO_W], wr_data[LO_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R3: plain step advances by exactly one word, wrapping
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !line_end && !wr_lo && !wr_hi) |=> (ptr == PTR_W'($past(ptr) + 1)));
    // R4: high write keeps the low half
    a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (ptr[LO_W-1:0] == $past(ptr[LO_W-1:0])
                   && ptr[PTR_W-1:LO_W] == $past(wr_data[HI_W-1:0])));
    // R4: low write keeps the high half
    a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (ptr[PTR_W-1:LO_W] == $past(ptr[PTR_W-1:LO_W])
                   && ptr[LO_W-1:0] == $past(wr_data[LO_W-1:0])));
    // R6: line end alone adds the sign-extended modulo
    a_r6_line_adds_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !step && !wr_lo && !wr_hi) |=>
            (ptr == PTR_W'($past(ptr) + {{EXT_W{$past(modulo[MOD_W-1])}}, $past(modulo)})));
    // R8: idle cycles leave the pointer untouched
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_end && !step && !wr_lo && !wr_hi) |=> $stable(ptr));
    // R4: one write half at a time
    a_r4_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && wr_hi));

endmodule

// File: rtl/bpl_issue.sv
module bpl_issue #(
    parameter int NUM_PLANES = 6,
    parameter int PTR_W      = 18,
    parameter int IDX_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [IDX_W-1:0] plane,
    input  logic [PTR_W-1:0] ptrs [NUM_PLANES],
    output logic             fetch_valid,
    output logic [PTR_W-1:0] fetch_addr,
    output logic [IDX_W-1:0] fetch_plane_o
);
    import bpl_pkg::*;

    iss_state_e       state_q, state_d;
    logic             req_ok;
    logic [PTR_W-1:0] sel_ptr;
    logic [PTR_W-1:0] addr_q;
    logic [IDX_W-1:0] plane_q;

    assign req_ok = req && (plane >= IDX_W'(1)) && (plane <= IDX_W'(NUM_PLANES));

    // Plane select mux
    always_comb begin
        sel_ptr = '0;
        for (int i = 0; i < NUM_PLANES; i++) begin
            if (plane == IDX_W'(i + 1)) sel_ptr = ptrs[i];
        end
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ISS_IDLE:  state_d = req_ok ? ISS_VALID : ISS_IDLE;
            ISS_VALID: state_d = req_ok ? ISS_VALID : ISS_IDLE;
            default:   state_d = ISS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ISS_IDLE;
        else        state_q <= state_d;
    end

    // Issued address and plane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            plane_q <= '0;
        end else if (req_ok) begin
            addr_q  <= sel_ptr;
            plane_q <= plane;
        end
    end

    // Outputs
    always_comb begin
        fetch_valid   = (state_q == ISS_VALID);
        fetch_addr    = addr_q;
        fetch_plane_o = plane_q;
    end

    // R2: valid only follows a legal request, and echoes its plane
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> ($past(req) && fetch_plane_o == $past(plane)));
    // R5: illegal plane codes are not issued
    a_r5_bad_plane_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (plane == '0 || plane > IDX_W'(NUM_PLANES))) |=> !fetch_valid);
    // R2: issued plane is always legal
    a_r2_plane_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_plane_o != '0 && fetch_plane_o <= IDX_W'(NUM_PLANES)));

endmodule

// File: rtl/bpl_ptr_gen.sv
module bpl_ptr_gen #(
    parameter int NUM_PLANES = 6,
    parameter int HI_W       = 3,
    parameter int LO_W       = 15,
    parameter int MOD_W      = 16,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 3,
    localparam int PTR_W     = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_kind,
    input  logic [IDX_W-1:0]  host_plane,
    input  logic [DATA_W-1:0] host_data,
    input  logic              fetch_req,
    input  logic [IDX_W-1:0]  fetch_plane,
    input  logic              line_end,
    output logic              fetch_valid,
    output logic [PTR_W-1:0]  fetch_addr,
    output logic [IDX_W-1:0]  fetch_plane_o
);
    import bpl_pkg::*;

    logic [MOD_W-1:0] mod_odd, mod_even;
    logic [PTR_W-1:0] ptrs [NUM_PLANES];
    logic             wr_lo_any, wr_hi_any;

    always_comb begin
        wr_lo_any = 1'b0;
        wr_hi_any = 1'b0;
        if (host_we) begin
            unique case (host_kind_e'(host_kind))
                HK_PTR_LO: wr_lo_any = 1'b1;
                HK_PTR_HI: wr_hi_any = 1'b1;
                default: ;
            endcase
        end
    end

    bpl_mod_regs #(.MOD_W(MOD_W)) u_mods (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_we),
        .kind     (host_kind),
        .data     (host_data[MOD_W-1:0]),
        .mod_odd  (mod_odd),
        .mod_even (mod_even)
    );

    for (genvar g = 0; g < NUM_PLANES; g++) begin : g_slot
        // Plane number g+1; odd planes sit at even indices
        localparam logic [IDX_W-1:0] PLANE_NUM = IDX_W'(g + 1);
        logic hit_wr, hit_fetch;
        logic [MOD_W-1:0] slot_mod;

        assign hit_wr    = (host_plane == PLANE_NUM);
        assign hit_fetch = fetch_req && (fetch_plane == PLANE_NUM);

        if ((g % 2) == 0) begin : g_odd
            assign slot_mod = mod_odd;
        end else begin : g_even
            assign slot_mod = mod_even;
        end

        bpl_ptr_slot #(
            .HI_W   (HI_W),
            .LO_W   (LO_W),
            .MOD_W  (MOD_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_any && hit_wr),
            .wr_hi    (wr_hi_any && hit_wr),
            .wr_data  (host_data),
            .step     (hit_fetch),
            .line_end (line_end),
            .modulo   (slot_mod),
            .ptr      (ptrs[g])
        );
    end

    bpl_issue #(
        .NUM_PLANES (NUM_PLANES),
        .PTR_W      (PTR_W),
        .IDX_W      (IDX_W)
    ) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (fetch_req),
        .plane         (fetch_plane),
        .ptrs          (ptrs),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_plane_o (fetch_plane_o)
    );

    // R1: nothing is issued in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !fetch_valid);

endmodule

// File: tb/bpl_ptr_gen_bench.sv
module bpl_ptr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_kind = 2'b00;
    logic [2:0]  host_plane = 3'd0;
    logic [15:0] host_data = 16'h0;
    logic        fetch_req = 1'b0;
    logic [2:0]  fetch_plane = 3'd0;
    logic        line_end = 1'b0;
    logic        fetch_valid;
    logic [17:0] fetch_addr;
    logic [2:0]  fetch_plane_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    int m_ptr [1:6];
    int m_mod_odd = 0;
    int m_mod_even = 0;

    always #4 clk = ~clk; // 125 MHz

    bpl_ptr_gen u_bpl_ptr_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_we       (host_we),
        .host_kind     (host_kind),
        .host_plane    (host_plane),
        .host_data     (host_data),
        .fetch_req     (fetch_req),
        .fetch_plane   (fetch_plane),
        .line_end      (line_end),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_plane_o (fetch_plane_o)
    );

    function automatic int sext16(input int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    // One clock: drive, update model, compare after the edge
    task automatic step(input bit we, input bit [1:0] kind, input bit [2:0] pl,
                        input bit [15:0] d, input bit fr, input bit [2:0] fp,
                        input bit eol, input string tag);
        bit exp_v;
        int exp_a;
        int nxt [1:6];
        @(negedge clk);
        host_we = we; host_kind = kind; host_plane = pl; host_data = d;
        fetch_req = fr; fetch_plane = fp; line_end = eol;
        exp_v = fr && fp >= 1 && fp <= 6;
        exp_a = exp_v ? m_ptr[fp] : 0;
        for (int p = 1; p <= 6; p++) begin
            int n = m_ptr[p];
            if (fr && fp == p) n = n + 1;
            if (eol) n = n + sext16((p % 2 == 1) ? m_mod_odd : m_mod_even);
            if (we && kind == 2'b00 && pl == p) n = (m_ptr[p] & 32'h38000) | (d & 32'h7FFF);
            if (we && kind == 2'b01 && pl == p) n = (m_ptr[p] & 32'h07FFF) | ((d & 7) << 15);
            nxt[p] = n & 32'h3FFFF;
        end
        for (int p = 1; p <= 6; p++) m_ptr[p] = nxt[p];
        if (we && kind == 2'b10) m_mod_odd = d;
        if (we && kind == 2'b11) m_mod_even = d;
        @(posedge clk);
        #1;
        n_tests++;
        if (fetch_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: fetch_valid=%0b expected %0b", tag, fetch_valid, exp_v);
        end else if (exp_v && (fetch_addr !== 18'(exp_a) || fetch_plane_o !== fp)) begin
            n_fail++;
            $display("FAIL %s: addr=%05h plane=%0d expected addr=%05h plane=%0d",
                     tag, fetch_addr, fetch_plane_o, exp_a, fp);
        end
    endtask

    task automatic fetch(input bit [2:0] p, input string tag);
        step(0, 2'b00, 3'd0, 16'h0, 1, p, 0, tag);
    endtask

    task automatic wr(input bit [1:0] k, input bit [2:0] p, input bit [15:0] d, input string tag);
        step(1, k, p, d, 0, 3'd0, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 2'b00, 3'd0, 16'h0, 0, 3'd0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 1; p <= 6; p++) m_ptr[p] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle("R1");
        for (int p = 1; p <= 6; p++) fetch(3'(p), "R1");

        // R4: halves written independently; R3: post-increment
        wr(2'b01, 3'd3, 16'hFFF5, "R4");
        wr(2'b00, 3'd3, 16'h9234, "R4");
        fetch(3'd3, "R4");
        fetch(3'd3, "R3");
        wr(2'b01, 3'd3, 16'h0002, "R4");
        fetch(3'd3, "R4");

        // R3: wrap at top of range
        wr(2'b01, 3'd1, 16'h0007, "R3");
        wr(2'b00, 3'd1, 16'h7FFF, "R3");
        fetch(3'd1, "R3");
        fetch(3'd1, "R3");
        fetch(3'd1, "R3");

        // R5: illegal plane codes
        fetch(3'd0, "R5");
        fetch(3'd7, "R5");
        wr(2'b00, 3'd0, 16'h1111, "R5");
        wr(2'b01, 3'd7, 16'h0005, "R5");
        for (int p = 1; p <= 6; p++) fetch(3'(p), "R5");

        // R6/R7: opposite-signed modulos by parity
        wr(2'b10, 3'd0, 16'd10, "R7");
        wr(2'b11, 3'd0, 16'hFFFC, "R7");
        step(0, 2'b00, 3'd0, 16'h0, 0, 3'd0, 1, "R6");
        for (int p = 1; p <= 6; p++) fetch(3'(p), "R6");

        // R6: negative modulo wraps below zero
        wr(2'b00, 3'd2, 16'h0000, "R6");
        wr(2'b01, 3'd2, 16'h0000, "R6");
        step(0, 2'b00, 3'd0, 16'h0, 0, 3'd0, 1, "R6");
        fetch(3'd2, "R6");

        // R7: modulo write during line end uses old value
        step(1, 2'b10, 3'd0, 16'd500, 0, 3'd0, 1, "R7");
        fetch(3'd5, "R7");
        step(0, 2'b00, 3'd0, 16'h0, 0, 3'd0, 1, "R7");
        fetch(3'd5, "R7");

        // R8: write beats fetch and line end on same plane
        step(1, 2'b00, 3'd4, 16'h0123, 1, 3'd4, 0, "R8");
        fetch(3'd4, "R8");
        step(1, 2'b01, 3'd6, 16'h0003, 0, 3'd0, 1, "R8");
        fetch(3'd6, "R8");
        step(1, 2'b00, 3'd1, 16'h0042, 1, 3'd1, 1, "R8");
        fetch(3'd1, "R8");

        // R9: fetch and line end together
        step(0, 2'b00, 3'd0, 16'h0, 1, 3'd3, 1, "R9");
        fetch(3'd3, "R9");
        step(0, 2'b00, 3'd0, 16'h0, 1, 3'd2, 1, "R9");
        fetch(3'd2, "R9");

        // R2: back-to-back and mixed random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            bit we = ($urandom_range(0, 3) == 0);
            step(we, 2'($urandom), 3'($urandom), 16'($urandom),
                 ($urandom_range(0, 2) != 0), 3'($urandom),
                 ($urandom_range(0, 9) == 0), "R2");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule